// File: doc/BRIEF.md
# Power-of-Two Segment Capability Unit

This unit interprets and updates a 64-bit compressed capability together with its separate validity tag. The word has three fields: a permission mask, an exponent E and a pointer address. The exponent defines a segment 2^E bytes long and aligned to 2^E that contains the address. The segment limits are therefore derived from the pointer itself and are not stored as separate fields.

Each request carries one of four operations: replace the address, add a signed offset, check an access, or inspect the capability unchanged. Arithmetic may move the pointer freely inside its segment. If a result lands anywhere else, the tag is dropped, so a valid pointer outside its segment cannot exist. An access check passes only when the tag is valid, the capability holds every requested permission, and the accessed bytes end at or below the segment top. The result and the segment limits of the resulting capability are registered one clock after the request.

Top module: `seg_cap_unit`

## Requirements
- R1: The capability word is laid out as follows: permissions in bits 63:60, exponent E in bits 59:54, and address in bits 53:0.
- R2: `out_base` is the result address with every bit below position E cleared. `out_top` is `out_base` plus 2^E, computed 55 bits wide, so E = 54 gives a top of 2^54. `out_addr` equals bits 53:0 of `out_cap`.
- R3: An exponent from 55 to 63 is reserved. The result tag is then cleared, `out_ok` is 0, and `out_base` and `out_top` are both 0.
- R4: Set address (op code 0) takes the 64-bit operand as the new pointer. The tag is kept only if operand bits 63:E equal the original address bits at those positions, where original bits 63:54 count as zero.
- R5: Add offset (op code 1) adds the 64-bit two's-complement operand to the address. The tag is kept only if the exact sum is non-negative and below 2^54, and its bits at and above E match the original address. The new address is the low 54 bits of the sum.
- R6: Permissions and exponent are copied unchanged into `out_cap`. The address field takes the computed address even when the tag is dropped.
- R7: A request whose input tag is 0 always yields `out_tag` = 0 and `out_ok` = 0.
- R8: Check (op code 2) leaves the capability unchanged. `out_ok` is 1 only when the tag is valid, every bit set in `in_perm_req` is also set in the permissions, and address plus `in_size` is no greater than the segment top.
- R9: Inspect (op code 3) returns the capability with its address unchanged, subject to R3 and R7.
- R10: `out_ok` is 0 for every operation other than check.
- R11: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, all result outputs hold their previous values.
- R12: A synchronous active-low reset clears `out_valid` and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_tag | input | 1 | Validity tag of the input capability |
| in_cap | input | 64 | Input capability word |
| in_op | input | 2 | 0 set address, 1 add offset, 2 check, 3 inspect |
| in_operand | input | 64 | New address or signed offset |
| in_size | input | 16 | Access size in bytes for a check |
| in_perm_req | input | 4 | Permission bits the access requires |
| out_valid | output | 1 | Result registered this cycle |
| out_tag | output | 1 | Tag of the resulting capability |
| out_cap | output | 64 | Resulting capability word |
| out_base | output | 54 | Decoded segment base of the result |
| out_top | output | 55 | Decoded segment top of the result |
| out_addr | output | 54 | Pointer address of the result |
| out_ok | output | 1 | Access permitted |

## Verification
The delicate cases arise where tag invalidation and bounds decoding happen in the same cycle. One example is an add that lands exactly on the segment top: the pointer leaves the segment through a carry into bit E, so the tag drops and the decoded base moves to the next segment. Another is a check whose access ends exactly at the top while a permission is missing, so the range test passes and the permission test fails. Directed vectors drive these cases at E = 0, E = 12, E = 54 and a reserved exponent. They are followed by random requests that concentrate offsets near 2^E. The reference model in the bench derives every output from the requirements and compares all of them on every clock.

// File: rtl/seg_cap_pkg.sv
// Shared field widths, operation codes and the capability layout
// for the power-of-two segment capability unit.
package seg_cap_pkg;
    localparam int PERM_W = 4;
    localparam int EXP_W  = 6;
    localparam int ADDR_W = 54;
    localparam int CAP_W  = PERM_W + EXP_W + ADDR_W;
    localparam int TOP_W  = ADDR_W + 1;
    localparam int OPND_W = 64;

    typedef enum logic [1:0] {
        OP_SET_ADDR = 2'd0,
        OP_ADD_OFF  = 2'd1,
        OP_CHECK    = 2'd2,
        OP_INSPECT  = 2'd3
    } op_e;

    typedef struct packed {
        logic [PERM_W-1:0] perm;
        logic [EXP_W-1:0]  expo;
        logic [ADDR_W-1:0] addr;
    } cap_t;
endpackage

// File: rtl/seg_cap_decode.sv
// Segment decoder: turns an exponent and an address into the base and
// top of the 2^E-aligned segment holding that address.
// Assumes ADDR_W < 2**EXP_W. Exponents above ADDR_W are reported as
// invalid and yield zero base and top.
module seg_cap_decode #(
    parameter int ADDR_W = 54,
    parameter int EXP_W  = 6
) (
    input  logic [EXP_W-1:0]  expo_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              expo_ok_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W:0]   top_o
);
    localparam int TOP_W = ADDR_W + 1;

    logic [ADDR_W-1:0] keep;

    // One mask bit per address position: kept when the position is at or above E.
    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
            assign keep[i] = (int'(expo_i) <= i);
        end
    endgenerate

    assign expo_ok_o = (int'(expo_i) <= ADDR_W);

    // Clears the bits below E to form the base; the top adds one segment length.
    always_comb begin
        if (expo_ok_o) begin
            base_o = addr_i & keep;
            top_o  = {1'b0, base_o} + (TOP_W'(1) << expo_i);
        end else begin
            base_o = '0;
            top_o  = '0;
        end
    end
endmodule

// File: rtl/seg_cap_modify.sv
// Address modifier: forms the candidate pointer for a set or add request
// and reports whether it stays inside the original segment.
// The candidate is kept two bits wider than the operand, so a wrap below
// zero or a carry past the address field shows up as a change above E.
module seg_cap_modify #(
    parameter int ADDR_W = 54,
    parameter int EXP_W  = 6,
    parameter int OPND_W = 64
) (
    input  seg_cap_pkg::op_e  op_i,
    input  logic [EXP_W-1:0]  expo_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [OPND_W-1:0] operand_i,
    output logic [ADDR_W-1:0] new_addr_o,
    output logic              stay_o
);
    import seg_cap_pkg::*;

    localparam int CW = OPND_W + 2;

    logic [CW-1:0] addr_ext;
    logic [CW-1:0] cand;
    logic [CW-1:0] hi_mask;

    assign addr_ext = CW'(addr_i);

    // Marks every candidate bit position at or above E.
    generate
        for (genvar i = 0; i < CW; i++) begin : g_hi
            assign hi_mask[i] = (int'(expo_i) <= i);
        end
    endgenerate

    // Picks the candidate pointer for the requested operation.
    always_comb begin
        case (op_i)
            OP_SET_ADDR: cand = {2'b00, operand_i};
            OP_ADD_OFF:  cand = addr_ext + {{2{operand_i[OPND_W-1]}}, operand_i};
            default:     cand = addr_ext;
        endcase
    end

    assign stay_o     = (((cand ^ addr_ext) & hi_mask) == '0);
    assign new_addr_o = cand[ADDR_W-1:0];
endmodule

// File: rtl/seg_cap_access.sv
// Access checker: decides whether an access of a given size at the pointer
// is permitted. Assumes SIZE_W <= ADDR_W, so the end address fits 55 bits.
module seg_cap_access #(
    parameter int ADDR_W = 54,
    parameter int PERM_W = 4,
    parameter int SIZE_W = 16
) (
    input  logic              enable_i,
    input  logic              tag_i,
    input  logic [PERM_W-1:0] perm_i,
    input  logic [PERM_W-1:0] req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [ADDR_W:0]   top_i,
    output logic              ok_o
);
    localparam int TOP_W = ADDR_W + 1;

    logic [TOP_W-1:0] end_addr;
    logic             perm_hit;

    assign end_addr = TOP_W'(addr_i) + TOP_W'(size_i);
    assign perm_hit = ((req_i & ~perm_i) == '0);

    // Combines the tag, permission and upper-range conditions.
    always_comb begin
        ok_o = enable_i && tag_i && perm_hit && (end_addr <= top_i);
    end
endmodule

// File: rtl/seg_cap_unit.sv
// Power-of-two segment capability unit (top).
// Decodes the incoming capability, applies the requested address operation,
// drops the tag when the pointer leaves its segment, evaluates access checks,
// and registers the result together with the decoded limits of the result.
// Assumes one request per cycle at most; the result appears one clock later.
module seg_cap_unit #(
    parameter int SIZE_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_tag,
    input  logic [63:0] in_cap,
    input  logic [1:0]  in_op,
    input  logic [63:0] in_operand,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [3:0]  in_perm_req,
    output logic        out_valid,
    output logic        out_tag,
    output logic [63:0] out_cap,
    output logic [53:0] out_base,
    output logic [54:0] out_top,
    output logic [53:0] out_addr,
    output logic        out_ok
);
    import seg_cap_pkg::*;

    cap_t              cap_in;
    op_e               op;
    logic              expo_ok;
    logic [ADDR_W-1:0] seg_base;
    logic [TOP_W-1:0]  seg_top;
    logic [ADDR_W-1:0] new_addr;
    logic              stay;
    logic              tag_next;
    logic              ok_next;
    cap_t              cap_next;
    logic              res_expo_ok;
    logic [ADDR_W-1:0] res_base;
    logic [TOP_W-1:0]  res_top;

    assign cap_in = cap_t'(in_cap);
    assign op     = op_e'(in_op);

    // Limits of the incoming capability, used by the access check.
    seg_cap_decode #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_dec_in (
        .expo_i    (cap_in.expo),
        .addr_i    (cap_in.addr),
        .expo_ok_o (expo_ok),
        .base_o    (seg_base),
        .top_o     (seg_top)
    );

    seg_cap_modify #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .OPND_W(OPND_W)) u_mod (
        .op_i       (op),
        .expo_i     (cap_in.expo),
        .addr_i     (cap_in.addr),
        .operand_i  (in_operand),
        .new_addr_o (new_addr),
        .stay_o     (stay)
    );

    assign tag_next = in_tag && expo_ok && stay;

    seg_cap_access #(.ADDR_W(ADDR_W), .PERM_W(PERM_W), .SIZE_W(SIZE_W)) u_acc (
        .enable_i (op == OP_CHECK),
        .tag_i    (tag_next),
        .perm_i   (cap_in.perm),
        .req_i    (in_perm_req),
        .addr_i   (cap_in.addr),
        .size_i   (in_size),
        .top_i    (seg_top),
        .ok_o     (ok_next)
    );

    // Assembles the result word: fields copied, address replaced.
    always_comb begin
        cap_next      = cap_in;
        cap_next.addr = new_addr;
    end

    // Limits reported for the resulting capability.
    seg_cap_decode #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_dec_out (
        .expo_i    (cap_next.expo),
        .addr_i    (cap_next.addr),
        .expo_ok_o (res_expo_ok),
        .base_o    (res_base),
        .top_o     (res_top)
    );

    // Result register: valid follows the request, data loads only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= 1'b0;
            out_cap   <= '0;
            out_base  <= '0;
            out_top   <= '0;
            out_addr  <= '0;
            out_ok    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tag  <= tag_next && res_expo_ok;
                out_cap  <= cap_next;
                out_base <= res_base;
                out_top  <= res_top;
                out_addr <= cap_next.addr;
                out_ok   <= ok_next;
            end
        end
    end

    // Segment base of the input is kept for the checker's view of the design.
    logic unused_base;
    assign unused_base = ^seg_base;
endmodule

// File: rtl/seg_cap_unit_chk.sv
// Property checker for seg_cap_unit, bound to every instance of the top.
module seg_cap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_tag,
    input logic [9:0]  in_fields,
    input logic [1:0]  in_op,
    input logic        out_valid,
    input logic        out_tag,
    input logic [63:0] out_cap,
    input logic [53:0] out_base,
    input logic [54:0] out_top,
    input logic [53:0] out_addr,
    input logic        out_ok
);
    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_tag && !out_ok);

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_fields_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_cap[63:54] == $past(in_fields));

    assert_tagless_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_tag |=> !out_tag && !out_ok);

    assert_ok_only_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op != 2'd2 |=> !out_ok);

    assert_reserved_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cap[59:54] > 6'd54 |-> !out_tag && !out_ok && out_top == '0);

    assert_ok_needs_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ok |-> out_tag);

    assert_inside_segment_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tag |-> out_addr >= out_base && {1'b0, out_addr} < out_top);

    assert_pow2_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cap[59:54] <= 6'd54 |-> $countones(out_top - {1'b0, out_base}) == 1);

    assert_addr_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr == out_cap[53:0]);
endmodule

bind seg_cap_unit seg_cap_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_fields (in_cap[63:54]),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_cap   (out_cap),
    .out_base  (out_base),
    .out_top   (out_top),
    .out_addr  (out_addr),
    .out_ok    (out_ok)
);

// File: tb/sim_seg_cap_unit.sv
module sim_seg_cap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_tag = 1'b0;
    logic [63:0] in_cap = '0;
    logic [1:0]  in_op = '0;
    logic [63:0] in_operand = '0;
    logic [15:0] in_size = '0;
    logic [3:0]  in_perm_req = '0;
    logic        out_valid, out_tag, out_ok;
    logic [63:0] out_cap;
    logic [53:0] out_base, out_addr;
    logic [54:0] out_top;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state of the registered outputs
    logic        e_valid = 0, e_tag = 0, e_ok = 0;
    logic [63:0] e_cap = '0;
    logic [53:0] e_base = '0, e_addr = '0;
    logic [54:0] e_top = '0;
    string       e_req = "R12";

    always #10 clk = ~clk;

    seg_cap_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_cap(in_cap), .in_op(in_op), .in_operand(in_operand),
        .in_size(in_size), .in_perm_req(in_perm_req),
        .out_valid(out_valid), .out_tag(out_tag), .out_cap(out_cap),
        .out_base(out_base), .out_top(out_top), .out_addr(out_addr),
        .out_ok(out_ok)
    );

    function automatic logic [63:0] mk(input logic [3:0] p, input int e, input logic [53:0] a);
        return {p, 6'(e), a};
    endfunction

    // behavioural reference: computes the next expected outputs
    task automatic model(input logic t, input logic [63:0] c, input logic [1:0] op,
                         input logic [63:0] opnd, input logic [15:0] sz, input logic [3:0] rq);
        int e;
        bit rsv, kept;
        logic signed [65:0] s, a_s, lim;
        logic [53:0] na, b;
        logic [54:0] tp, seg_top;
        e    = int'(c[59:54]);
        rsv  = (e > 54);
        a_s  = $signed({12'b0, c[53:0]});
        lim  = 66'sd1 <<< 54;
        case (op)
            2'd0:    s = $signed({2'b00, opnd});
            2'd1:    s = a_s + $signed({{2{opnd[63]}}, opnd});
            default: s = a_s;
        endcase
        kept = (s >= 0) && (s < lim) && ((s >>> e) == (a_s >>> e));
        na   = s[53:0];
        seg_top = rsv ? 55'd0 : (({1'b0, c[53:0]} >> e) << e) + (55'd1 << e);
        if (rsv) begin b = '0; tp = '0; end
        else begin b = (na >> e) << e; tp = {1'b0, b} + (55'd1 << e); end
        e_tag  = t && !rsv && kept;
        e_ok   = (op == 2'd2) && e_tag && ((c[63:60] & rq) == rq) &&
                 ({1'b0, c[53:0]} + 55'(sz) <= seg_top);
        e_cap  = {c[63:54], na};
        e_addr = na;
        e_base = b;
        e_top  = tp;
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || out_tag !== e_tag || out_ok !== e_ok ||
            out_cap !== e_cap || out_base !== e_base || out_top !== e_top ||
            out_addr !== e_addr) begin
            errors++;
            $display("FAIL %s: got v=%b t=%b ok=%b cap=%h base=%h top=%h addr=%h exp v=%b t=%b ok=%b cap=%h base=%h top=%h addr=%h",
                     e_req, out_valid, out_tag, out_ok, out_cap, out_base, out_top, out_addr,
                     e_valid, e_tag, e_ok, e_cap, e_base, e_top, e_addr);
        end
    endtask

    // one clock: check the previous result, then drive the next request
    task automatic step(input string req, input logic rst, input logic v, input logic t,
                        input logic [63:0] c, input logic [1:0] op, input logic [63:0] opnd,
                        input logic [15:0] sz, input logic [3:0] rq);
        @(negedge clk);
        compare();
        rst_n = rst; in_valid = v; in_tag = t; in_cap = c; in_op = op;
        in_operand = opnd; in_size = sz; in_perm_req = rq;
        e_req = req;
        if (!rst) begin
            e_valid = 0; e_tag = 0; e_ok = 0; e_cap = '0;
            e_base = '0; e_top = '0; e_addr = '0;
        end else begin
            e_valid = v;
            if (v) model(t, c, op, opnd, sz, rq);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] c12;
        c12 = mk(4'hF, 12, 54'h5100);
        // R12 reset state, including a request presented during reset
        step("R12", 0, 0, 0, '0, 0, '0, 0, 0);
        step("R12", 0, 1, 1, c12, 2'd2, '0, 16'h10, 4'h1);
        step("R12", 1, 0, 0, '0, 0, '0, 0, 0);
        // R8 checks: inside, ending exactly at top, one byte past, missing permission
        step("R8", 1, 1, 1, c12, 2'd2, '0, 16'h10, 4'h3);
        step("R8", 1, 1, 1, mk(4'hF, 12, 54'h5FF0), 2'd2, '0, 16'h10, 4'hF);
        step("R8", 1, 1, 1, mk(4'hF, 12, 54'h5FF0), 2'd2, '0, 16'h11, 4'hF);
        step("R8", 1, 1, 1, mk(4'b0101, 12, 54'h5FF0), 2'd2, '0, 16'h10, 4'b0010);
        step("R8", 1, 1, 1, mk(4'b0101, 12, 54'h5FF0), 2'd2, '0, 16'h10, 4'b0100);
        // R5 add: inside, exactly at top, below base, 2^54 wrap
        step("R5", 1, 1, 1, c12, 2'd1, 64'h0EFF, 0, 0);
        step("R5", 1, 1, 1, c12, 2'd1, 64'h0F00, 0, 0);
        step("R5", 1, 1, 1, c12, 2'd1, -64'sh101, 0, 0);
        step("R5", 1, 1, 1, c12, 2'd1, 64'h0040_0000_0000_0000, 0, 0);
        // R4 set address at E=0 and E=12, and with high operand bits
        step("R4", 1, 1, 1, mk(4'h3, 0, 54'h1234), 2'd0, 64'h1234, 0, 0);
        step("R4", 1, 1, 1, mk(4'h3, 0, 54'h1234), 2'd0, 64'h1235, 0, 0);
        step("R4", 1, 1, 1, c12, 2'd0, 64'h5ABC, 0, 0);
        step("R4", 1, 1, 1, c12, 2'd0, 64'h8000_0000_0000_5ABC, 0, 0);
        // R2 whole-space segment at E=54: top 2^54, overflow past the space
        step("R2", 1, 1, 1, mk(4'hF, 54, 54'h3F_0000_0000_0000), 2'd1, 64'h1000, 0, 0);
        step("R5", 1, 1, 1, mk(4'hF, 54, 54'h3F_FFFF_FFFF_FFFF), 2'd1, 64'h1, 0, 0);
        step("R8", 1, 1, 1, mk(4'hF, 54, 54'h3F_FFFF_FFFF_FFF0), 2'd2, '0, 16'h10, 4'hF);
        // R3 reserved exponents
        step("R3", 1, 1, 1, mk(4'hF, 55, 54'h100), 2'd2, '0, 16'h1, 4'h0);
        step("R3", 1, 1, 1, mk(4'hF, 63, 54'h100), 2'd3, '0, 0, 0);
        // R7 untagged input, R9 inspect, R10 ok stays low outside check
        step("R7", 1, 1, 0, c12, 2'd2, '0, 16'h1, 4'h0);
        step("R7", 1, 1, 0, c12, 2'd1, 64'h4, 0, 0);
        step("R9", 1, 1, 1, c12, 2'd3, 64'hFFFF, 16'h1, 4'h0);
        step("R10", 1, 1, 1, c12, 2'd0, 64'h5100, 16'h1, 4'h0);
        // R11 idle cycles with garbage inputs hold outputs
        step("R11", 1, 0, 1, mk(4'h0, 3, 54'h7), 2'd1, 64'h99, 16'h5, 4'h5);
        step("R11", 1, 0, 0, '0, 2'd2, '0, 0, 0);
        // R6 fields kept on an invalidating add
        step("R6", 1, 1, 1, mk(4'hA, 20, 54'h12_3456), 2'd1, 64'h10_0000, 0, 0);
        // R12 reset in mid-run
        step("R12", 0, 1, 1, c12, 2'd2, '0, 16'h1, 4'h1);
        step("R12", 1, 0, 0, '0, 0, '0, 0, 0);
        // R1 layout exercised by random traffic with offsets scaled near 2^E
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] r, opnd, c;
            logic [1:0] op;
            int e, sh;
            e  = (n % 10 == 0) ? $urandom_range(55, 63) : $urandom_range(0, 54);
            c  = {4'($urandom), 6'(e), 54'({$urandom, $urandom})};
            op = 2'($urandom);
            r  = {$urandom, $urandom};
            sh = (e < 60) ? 62 - e : 0;
            if (op == 2'd1) opnd = 64'($signed(r) >>> sh);
            else if (op == 2'd0) opnd = {10'b0, c[53:0]} ^ (r >> $urandom_range(0, 63));
            else opnd = r;
            step(op == 2'd0 ? "R4" : op == 2'd1 ? "R5" : op == 2'd2 ? "R8" : "R1",
                 1, ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) != 0), c, op, opnd,
                 16'($urandom >> $urandom_range(0, 31)), 4'($urandom));
        end
        step("R11", 1, 0, 0, '0, 0, '0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule